// File: doc/BRIEF.md
# Real-Time Frame Receive Filter

This block sits on the receive side of one switch port and watches the incoming stream of 64-bit words. Each frame is parsed on its own, with no dependence on whatever the schedule engine is doing. A frame is accepted only if it is a well-formed time-triggered message. Its payload then lands in the receive buffer that belongs to the logical channel named in its header. A frame that fails any check is dropped and leaves every buffer exactly as it was.

Payload words first go into a staging store. Only after the final word has been judged is the staging content copied into the chosen channel buffer. In the same cycle that buffer's valid flag, stored length and stored telegram count are updated. A schedule engine reads any buffer word through a registered read port and also sees that channel's flag, length and count. Two one-cycle pulses report the verdict on each frame.

Input stream rules: a word moves when `s_valid` and `s_ready` are both high at a rising edge, and `s_last` marks the final word of a frame. `s_ready` is low only during reset and high in every cycle after it, so the block never applies back-pressure. The sender may insert idle cycles (`s_valid` low) anywhere.

Frame layout, with the first byte in bits [63:56] of each word:
- Word 0: destination address in [63:16] and the top 16 bits of the source address in [15:0].
- Word 1: the low 32 source bits in [63:32], the type field in [31:16] and the payload length in 64-bit words in [15:0].
- Word 2: channel in [63:48], variable ID in [47:32], telegram count in [31:16] and a reserved field in [15:0].
- Words 3 onward: payload.

Top module: `rt_rx_filter`

## Requirements
- R1: A frame whose destination field (word 0 bits [63:16]) is not all ones is rejected.
- R2: A frame whose type field (word 1 bits [31:16]) differs from 0x5CE0 is rejected.
- R3: A frame whose channel field (word 2 bits [63:48]) is NUM_CH or above is rejected; otherwise that field selects the one buffer that receives the payload.
- R4: A frame is rejected if its length field (word 1 bits [15:0]) is zero, exceeds DEPTH, or differs from the number of words after word 2; a frame that ends before word 2 is rejected.
- R5: The source address, variable ID (word 2 bits [47:32]) and reserved field (word 2 bits [15:0]) have no effect on acceptance or on stored content.
- R6: After an accepted frame, the selected buffer holds payload word k at index k for k below the length, reads zero at higher indices, and has valid flag 1, the stored length and the telegram count from word 2 bits [31:16]; other channels keep their content.
- R7: A rejected frame changes no buffer word, valid flag, length or telegram count, and a valid flag never returns to 0 after reset.
- R8: `s_ready` is high in every cycle after reset, including the cycles of a commit.
- R9: Exactly one of `frame_ok` and `frame_bad` pulses for one cycle right after the edge that accepts a word with `s_last`; both stay low after every other word.
- R10: The read port is registered: `rd_data`, `rd_valid`, `rd_tcnt` and `rd_len` show the addressed channel and word one clock edge after the address is applied, and a buffer commit becomes readable on the edge after the verdict pulse.
- R11: After reset, every buffer word, valid flag, length and count is zero and both verdict pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream word present |
| s_ready | output | 1 | Block accepts a word (high after reset) |
| s_data | input | 64 | Stream word |
| s_last | input | 1 | Final word of the frame |
| rd_ch | input | CH_W (2) | Channel to read |
| rd_word | input | AW (3) | Word index inside the channel buffer |
| rd_data | output | 64 | Registered buffer word |
| rd_valid | output | 1 | Registered valid flag of the channel |
| rd_tcnt | output | 16 | Registered stored telegram count |
| rd_len | output | LEN_W (4) | Registered stored payload length |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| frame_bad | output | 1 | One-cycle pulse: frame rejected |

## Verification
The verdict pulse is due one edge after the final word is taken, so the bench samples it at the falling edge that follows that word. It also confirms both pulses are low after every earlier word, with random idle gaps between words. The buffer copy lands on the next edge and the read port adds one more. The bench therefore waits one idle cycle before reading, and checks each addressed word one edge after applying its address. Every channel and word is read back after each frame, so the untouched channels are compared as well.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  localparam int          WORD_W    = 64;
  localparam int          HDR_WORDS = 3;
  localparam logic [15:0] RT_ETYPE  = 16'h5CE0;
  localparam logic [47:0] BCAST     = 48'hFFFF_FFFF_FFFF;
endpackage

// File: rtl/rtf_hdr_parse.sv
module rtf_hdr_parse
  import rtf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [WORD_W-1:0] data,
  input  logic              last,
  output logic              stg_we,
  output logic [AW-1:0]     stg_addr,
  output logic              cm_valid,
  output logic [CH_W-1:0]   cm_ch,
  output logic [LEN_W-1:0]  cm_len,
  output logic [15:0]       cm_tcnt,
  output logic              ok_pulse,
  output logic              bad_pulse
);
  localparam int CNT_W   = $clog2(DEPTH + HDR_WORDS + 1) + 1;
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic [CNT_W-1:0] idx_q;
  logic [47:0]      dst_q;
  logic [15:0]      etype_q, dlen_q, chan_q, tcnt_q;
  logic [15:0]      chan_e, tcnt_e;
  logic [CNT_W-1:0] pidx;
  logic             hdr_done, verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (beat) begin
      if (last)                 idx_q <= '0;
      else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      etype_q <= '0;
      dlen_q  <= '0;
      chan_q  <= '0;
      tcnt_q  <= '0;
    end else if (beat) begin
      case (idx_q)
        CNT_W'(0): dst_q <= data[63:16];
        CNT_W'(1): begin
          etype_q <= data[31:16];
          dlen_q  <= data[15:0];
        end
        CNT_W'(2): begin
          chan_q <= data[63:48];
          tcnt_q <= data[31:16];
        end
        default: ;
      endcase
    end
  end

  assign chan_e   = (idx_q == CNT_W'(2)) ? data[63:48] : chan_q;
  assign tcnt_e   = (idx_q == CNT_W'(2)) ? data[31:16] : tcnt_q;
  assign hdr_done = idx_q >= CNT_W'(2);
  assign pidx     = idx_q - CNT_W'(HDR_WORDS);

  always_comb begin
    verdict = hdr_done
           && (dst_q == BCAST)
           && (etype_q == RT_ETYPE)
           && (32'(chan_e) < 32'(NUM_CH))
           && (dlen_q != 16'd0)
           && (32'(dlen_q) <= 32'(DEPTH))
           && (32'(idx_q) - 32'd2 == 32'(dlen_q));
  end

  assign stg_we   = beat && (idx_q >= CNT_W'(HDR_WORDS)) && (32'(pidx) < 32'(DEPTH));
  assign stg_addr = pidx[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_valid  <= 1'b0;
      ok_pulse  <= 1'b0;
      bad_pulse <= 1'b0;
      cm_ch     <= '0;
      cm_len    <= '0;
      cm_tcnt   <= '0;
    end else if (beat && last) begin
      cm_valid  <= verdict;
      ok_pulse  <= verdict;
      bad_pulse <= !verdict;
      cm_ch     <= chan_e[CH_W-1:0];
      cm_len    <= dlen_q[LEN_W-1:0];
      cm_tcnt   <= tcnt_e;
    end else begin
      cm_valid  <= 1'b0;
      ok_pulse  <= 1'b0;
      bad_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/rtf_stage.sv
module rtf_stage
  import rtf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic [DEPTH-1:0][WORD_W-1:0] words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  words       <= '0;
    else if (we) words[addr] <= wdata;
  end
endmodule

// File: rtl/rtf_chan_bufs.sv
module rtf_chan_bufs
  import rtf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cm_valid,
  input  logic [CH_W-1:0]              cm_ch,
  input  logic [LEN_W-1:0]             cm_len,
  input  logic [15:0]                  cm_tcnt,
  input  logic [DEPTH-1:0][WORD_W-1:0] stage,
  input  logic [CH_W-1:0]              rd_ch,
  input  logic [AW-1:0]                rd_word,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_valid,
  output logic [15:0]                  rd_tcnt,
  output logic [LEN_W-1:0]             rd_len,
  output logic [NUM_CH-1:0]            valid_vec
);
  logic [NUM_CH-1:0][DEPTH-1:0][WORD_W-1:0] mem_all;
  logic [NUM_CH-1:0][15:0]                  tc_all;
  logic [NUM_CH-1:0][LEN_W-1:0]             len_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DEPTH-1:0][WORD_W-1:0] mem_q;
    logic                         val_q;
    logic [15:0]                  tc_q;
    logic [LEN_W-1:0]             len_q;
    logic                         hit;

    assign hit = cm_valid && (cm_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q <= '0;
        val_q <= 1'b0;
        tc_q  <= '0;
        len_q <= '0;
      end else if (hit) begin
        for (int w = 0; w < DEPTH; w++)
          mem_q[w] <= (32'(w) < 32'(cm_len)) ? stage[w] : '0;
        val_q <= 1'b1;
        tc_q  <= cm_tcnt;
        len_q <= cm_len;
      end
    end

    assign mem_all[c]   = mem_q;
    assign valid_vec[c] = val_q;
    assign tc_all[c]    = tc_q;
    assign len_all[c]   = len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_tcnt  <= '0;
      rd_len   <= '0;
    end else if (32'(rd_ch) < 32'(NUM_CH)) begin
      rd_data  <= (32'(rd_word) < 32'(DEPTH)) ? mem_all[rd_ch][rd_word] : '0;
      rd_valid <= valid_vec[rd_ch];
      rd_tcnt  <= tc_all[rd_ch];
      rd_len   <= len_all[rd_ch];
    end else begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_tcnt  <= '0;
      rd_len   <= '0;
    end
  end
endmodule

// File: rtl/rt_rx_filter.sv
module rt_rx_filter
  import rtf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [AW-1:0]     rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [15:0]       rd_tcnt,
  output logic [LEN_W-1:0]  rd_len,
  output logic              frame_ok,
  output logic              frame_bad
);
  logic                         rdy_q, beat;
  logic                         stg_we;
  logic [AW-1:0]                stg_addr;
  logic [DEPTH-1:0][WORD_W-1:0] stg_words;
  logic                         cm_valid;
  logic [CH_W-1:0]              cm_ch;
  logic [LEN_W-1:0]             cm_len;
  logic [15:0]                  cm_tcnt;
  logic [NUM_CH-1:0]            ch_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign s_ready = rdy_q;
  assign beat    = s_valid && rdy_q;

  rtf_hdr_parse #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) parse_i (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(s_data), .last(s_last),
    .stg_we(stg_we), .stg_addr(stg_addr),
    .cm_valid(cm_valid), .cm_ch(cm_ch), .cm_len(cm_len), .cm_tcnt(cm_tcnt),
    .ok_pulse(frame_ok), .bad_pulse(frame_bad)
  );

  rtf_stage #(.DEPTH(DEPTH)) stage_i (
    .clk(clk), .rst_n(rst_n), .we(stg_we), .addr(stg_addr),
    .wdata(s_data), .words(stg_words)
  );

  rtf_chan_bufs #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) bufs_i (
    .clk(clk), .rst_n(rst_n),
    .cm_valid(cm_valid), .cm_ch(cm_ch), .cm_len(cm_len), .cm_tcnt(cm_tcnt),
    .stage(stg_words),
    .rd_ch(rd_ch), .rd_word(rd_word),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_tcnt(rd_tcnt), .rd_len(rd_len),
    .valid_vec(ch_valid)
  );
endmodule

// File: rtl/rtf_chk.sv
module rtf_chk #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              frame_ok,
  input logic              frame_bad,
  input logic [CH_W-1:0]   cm_ch,
  input logic [NUM_CH-1:0] ch_valid
);
  a_r9_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));

  a_r9_verdict_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || frame_bad) |-> $past(s_valid && s_ready && s_last));

  a_r8_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);

  a_r6_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> ch_valid[$past(cm_ch)]);

  a_r7_reject_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> (ch_valid == $past(ch_valid)));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid & $past(ch_valid)) == $past(ch_valid));
endmodule

bind rt_rx_filter rtf_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .frame_ok(frame_ok), .frame_bad(frame_bad),
  .cm_ch(cm_ch), .ch_valid(ch_valid)
);

// File: tb/rt_rx_filter_tb_top.sv
module rt_rx_filter_tb_top;
  localparam int CLK_NS = 10;
  localparam int NUM_CH = 4;
  localparam int DEPTH  = 8;
  localparam int CH_W   = 2;
  localparam int AW     = 3;
  localparam int LEN_W  = 4;
  localparam int MAXW   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic [63:0]      s_data = '0;
  logic             s_last = 1'b0;
  logic [CH_W-1:0]  rd_ch = '0;
  logic [AW-1:0]    rd_word = '0;
  logic [63:0]      rd_data;
  logic             rd_valid;
  logic [15:0]      rd_tcnt;
  logic [LEN_W-1:0] rd_len;
  logic             frame_ok, frame_bad;

  rt_rx_filter #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .rd_ch(rd_ch), .rd_word(rd_word),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_tcnt(rd_tcnt), .rd_len(rd_len),
    .frame_ok(frame_ok), .frame_bad(frame_bad)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] frm [MAXW];
  int          nw;
  logic [63:0] m_data [NUM_CH][DEPTH];
  bit          m_val  [NUM_CH];
  logic [15:0] m_tc   [NUM_CH];
  int          m_len  [NUM_CH];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit frame_pass();
    logic [15:0] dl, ch;
    if (nw < 3) return 0;
    if (frm[0][63:16] != 48'hFFFF_FFFF_FFFF) return 0;
    if (frm[1][31:16] != 16'h5CE0) return 0;
    dl = frm[1][15:0];
    ch = frm[2][63:48];
    if (int'(ch) >= NUM_CH) return 0;
    if (dl == 16'd0 || int'(dl) > DEPTH) return 0;
    if (int'(dl) != nw - 3) return 0;
    return 1;
  endfunction

  // kind: 0 good, 1 bad dst, 2 bad type, 3 bad channel, 4 long len,
  // 5 count mismatch, 6 short frame, 7 zero len
  task automatic build(int kind, int fch, int flen);
    int          ch = (fch >= 0) ? fch : int'($urandom_range(NUM_CH - 1));
    int          ln = (flen >= 1) ? flen : int'($urandom_range(DEPTH, 1));
    int          pw;
    logic [47:0] dst = 48'hFFFF_FFFF_FFFF;
    logic [47:0] src = 48'({$urandom, $urandom});
    logic [15:0] et  = 16'h5CE0;
    logic [15:0] dlf;
    pw  = ln;
    dlf = 16'(ln);
    case (kind)
      1: dst = dst ^ (48'd1 << $urandom_range(47));
      2: et  = et ^ (16'd1 << $urandom_range(15));
      3: if (fch < 0) ch = NUM_CH + int'($urandom_range(200));
      4: begin dlf = 16'(DEPTH + 1 + int'($urandom_range(3))); pw = int'(dlf); end
      5: pw = (ln == 1 || $urandom_range(1) == 1) ? ln + 1 : ln - 1;
      7: begin dlf = 16'd0; pw = 0; end
      default: ;
    endcase
    frm[0] = {dst, src[47:32]};
    frm[1] = {src[31:0], et, dlf};
    frm[2] = {16'(ch), 16'($urandom), 16'($urandom), 16'($urandom)};
    for (int i = 0; i < pw; i++) frm[3 + i] = {$urandom, $urandom};
    nw = 3 + pw;
    if (kind == 6) nw = int'($urandom_range(2, 1));
  endtask

  task automatic send(string tag);
    bit pass = frame_pass();
    for (int i = 0; i < nw; i++) begin
      for (int g = int'($urandom_range(2)); g > 0; g--) begin
        s_valid = 1'b0;
        s_data  = {$urandom, $urandom};
        s_last  = $urandom_range(1) == 1;
        @(negedge clk);
      end
      s_valid = 1'b1;
      s_data  = frm[i];
      s_last  = (i == nw - 1);
      @(posedge clk);
      @(negedge clk);
      chk("R8 ready", 64'(s_ready), 64'd1);
      if (i == nw - 1) begin
        chk({"R9 ok pulse ", tag}, 64'(frame_ok), 64'(pass));
        chk({"R9 bad pulse ", tag}, 64'(frame_bad), 64'(!pass));
      end else begin
        chk("R9 no pulse mid-frame", 64'(frame_ok | frame_bad), 64'd0);
      end
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    if (pass) begin
      int c  = int'(frm[2][63:48]);
      int ln = int'(frm[1][15:0]);
      for (int w = 0; w < DEPTH; w++) m_data[c][w] = (w < ln) ? frm[3 + w] : 64'd0;
      m_val[c] = 1'b1;
      m_tc[c]  = frm[2][31:16];
      m_len[c] = ln;
    end
    @(negedge clk);
  endtask

  task automatic readback(string tag);
    for (int c = 0; c < NUM_CH; c++) begin
      for (int w = 0; w < DEPTH; w++) begin
        rd_ch   = CH_W'(c);
        rd_word = AW'(w);
        @(negedge clk);
        chk({tag, " R10 data"}, rd_data, m_data[c][w]);
        if (w == 0) begin
          chk({tag, " R10 valid"}, 64'(rd_valid), 64'(m_val[c]));
          chk({tag, " R10 tcnt"},  64'(rd_tcnt), 64'(m_tc[c]));
          chk({tag, " R10 len"},   64'(rd_len), 64'(m_len[c]));
        end
      end
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < NUM_CH; c++) begin
      for (int w = 0; w < DEPTH; w++) m_data[c][w] = '0;
      m_val[c] = 0; m_tc[c] = '0; m_len[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ok after reset", 64'(frame_ok), 64'd0);
    chk("R11 bad after reset", 64'(frame_bad), 64'd0);
    chk("R8 ready after reset", 64'(s_ready), 64'd1);
    readback("R11 reset");

    build(0, 0, DEPTH);           send("R6 full depth ch0");        readback("R6");
    build(0, NUM_CH - 1, 1);      send("R3 last channel len1");     readback("R3");
    build(3, NUM_CH, 2);          send("R3 channel at limit");      readback("R7 R3");
    build(4, 1, -1);              send("R4 len above depth");       readback("R7 R4");
    build(5, 2, 3);               send("R4 count mismatch");        readback("R7 R4");
    build(6, 2, 3);               send("R4 short frame");           readback("R7 R4");
    build(7, 2, 3);               send("R4 zero len");              readback("R7 R4");
    build(1, 2, 4);               send("R1 bad dst");               readback("R7 R1");
    build(2, 2, 4);               send("R2 bad type");              readback("R7 R2");
    build(0, 0, 2);               send("R6 shorter overwrite");     readback("R6 zero tail");
    build(0, 2, 5);               send("R5 random src varid rsv");  readback("R5");

    for (int n = 0; n < 40; n++) begin
      int k = ($urandom_range(9) < 4) ? 0 : int'($urandom_range(7, 1));
      build(k, -1, -1);
      send("random");
      readback("R6 R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule